// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reset request of a small microcontroller into one system reset that is synchronous to the system clock. There is one asynchronous power-on input. It clears the controller itself and holds the chip in reset. Eight more request inputs cover the following sources:

- supply monitor
- external reset pin
- missing-clock detector
- watchdog
- comparator
- software request
- illegal flash operation
- real-time-clock alarm

Each request passes through a two-flop synchronizer. Any one of them alone is enough to hold the chip in reset. Reset is released only after a fixed quiet interval.

The controller also does the following:

- It drives the open-drain, active-low reset pin, but only for power-on and supply-monitor resets.
- It masks its own drive so that the pin never looks like an external request.
- It records the causes of the most recent reset in a flag vector.
- It presents the defaults that hold after reset exit: start address, clock choice, watchdog enable with a divide-by-12 tick, and the state of the port latches.

All pins carry control or status levels. No data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `rstctl_top`

## Requirements
- R1: Every non-power-on request input acts alone. An input held high for at least one clock drives `sys_rst` high, visible after the third rising edge that follows the input going high.
- R2: `sys_rst` stays high while any synchronized request is present. It falls on the 18th rising edge after the last request input goes low, which means 16 consecutive edges with no synchronized request.
- R3: While `por_req` is high, the outputs take these values at once: `sys_rst`=1, `pin_drive`=1 and `rst_flags`=0x001. After `por_req` falls, `sys_rst` falls on the 16th rising edge, provided no other request arrives.
- R4: `pin_drive` is high only during a reset started by power-on or by the supply monitor. It stays high until `sys_rst` falls and drops on that same edge. Resets from any other source leave `pin_drive` low.
- R5: When the pin is low because of the block's own drive, including the two cycles after the drive ends, the pin is not taken as a request. A low level from outside is a request and is recorded in flag bit 2.
- R6: `rst_flags` bit order is: 0 power-on, 1 supply monitor, 2 pin, 3 missing clock, 4 watchdog, 5 comparator, 6 software, 7 flash error, 8 real-time clock. On entry to reset the vector is cleared and loaded with the requests present. Requests that appear while the block is already in reset are ORed in. The vector holds its value after exit.
- R7: A missing-clock pulse one clock wide produces a full reset of the same length as a held request.
- R8: `boot_addr` is 0x0000 and `clk_sel` is 0, meaning the internal oscillator. `wdt_div` reads 12. `wdt_en` is 0 during reset and 1 after exit.
- R9: Outside reset, `wdt_tick` is a one-cycle pulse every 12 clocks. The first pulse is visible after the 12th rising edge, counting the edge on which `sys_rst` falls as the first. During reset, `wdt_tick` is 0.
- R10: `port_val` is 0xFF, and `port_od` and `port_pullup` are both 1, during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, asynchronous, active high |
| supmon_req | input | 1 | Supply-monitor request |
| pin_rst_n | input | 1 | Sensed level of the reset pin, low = reset |
| mcd_pulse | input | 1 | Missing-clock one-shot pulse |
| wdt_req | input | 1 | Watchdog timeout request |
| cmp_req | input | 1 | Comparator request |
| sw_req | input | 1 | Software reset request |
| flash_err_req | input | 1 | Illegal flash operation request |
| rtc_req | input | 1 | Real-time-clock alarm request |
| sys_rst | output | 1 | System reset, active high |
| pin_drive | output | 1 | Pull the reset pin low when 1 |
| rst_flags | output | 9 | Reset cause flags |
| boot_addr | output | 16 | Start address after exit |
| clk_sel | output | 2 | System clock choice, 0 = internal oscillator |
| wdt_en | output | 1 | Watchdog enable |
| wdt_div | output | 4 | Watchdog clock divide ratio |
| wdt_tick | output | 1 | Watchdog clock-enable pulse |
| port_val | output | 8 | Port latch value |
| port_od | output | 1 | Port open-drain mode |
| port_pullup | output | 1 | Port weak pull-up enable |

## Verification
A request takes three edges to reach `sys_rst`: two synchronizer stages and the reset register. Release is due on the 18th edge after the last request falls, and the first watchdog tick is due on the 12th edge after release. The bench reference model delays the raw requests through a two-entry queue and counts quiet edges and divider steps with integers. Inputs change 1 ns after a falling edge, and every output is compared with the model on each falling edge, half a period after the register updates. Tests that drive the pin from outside keep well clear of the windows in which the block drives the pin itself.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int NREQ = 8;
  // index of each synchronized request in the request vector
  localparam int RQ_SUPMON = 0;
  localparam int RQ_PIN    = 1;
  localparam int RQ_MCD    = 2;
  localparam int RQ_WDT    = 3;
  localparam int RQ_CMP    = 4;
  localparam int RQ_SW     = 5;
  localparam int RQ_FLASH  = 6;
  localparam int RQ_RTC    = 7;

  typedef enum logic [1:0] {
    CLK_INTOSC = 2'd0,
    CLK_EXTOSC = 2'd1,
    CLK_RTCOSC = 2'd2,
    CLK_ALTSRC = 2'd3
  } clk_choice_e;
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge arst) begin
      if (arst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rstctl_core.sv
module rstctl_core
  import rstctl_pkg::*;
#(
  parameter int HOLD   = 16,
  parameter int MASK_D = 2
) (
  input  logic            clk,
  input  logic            por,
  input  logic [NREQ-1:0] req_s,
  output logic            sys_rst,
  output logic            pin_drive,
  output logic [NREQ:0]   flags
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0]     quiet_cnt;
  logic              drv_cause;
  logic [MASK_D-1:0] drv_hist;
  logic              self_mask;
  logic [NREQ-1:0]   req_eff;
  logic              any_eff;

  assign pin_drive = sys_rst & drv_cause;
  assign self_mask = pin_drive | (|drv_hist);

  always_comb begin
    req_eff         = req_s;
    req_eff[RQ_PIN] = req_s[RQ_PIN] & ~self_mask;
  end
  assign any_eff = |req_eff;

  // history of our own drive, matching the pin synchronizer latency
  always_ff @(posedge clk or posedge por) begin
    if (por) drv_hist <= '1;
    else     drv_hist <= {drv_hist[MASK_D-2:0], pin_drive};
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      sys_rst   <= 1'b1;
      quiet_cnt <= '0;
      drv_cause <= 1'b1;
      flags     <= {{NREQ{1'b0}}, 1'b1};
    end else if (any_eff) begin
      sys_rst   <= 1'b1;
      quiet_cnt <= '0;
      if (req_eff[RQ_SUPMON]) drv_cause <= 1'b1;
      if (!sys_rst) flags <= {req_eff, 1'b0};
      else          flags <= flags | {req_eff, 1'b0};
    end else if (sys_rst) begin
      if (quiet_cnt == CW'(HOLD-1)) begin
        sys_rst   <= 1'b0;
        drv_cause <= 1'b0;
        quiet_cnt <= '0;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  AST_ENTRY: assert property (@(posedge clk) disable iff (por)
    any_eff |=> sys_rst); // R1
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (por)
    $fell(sys_rst) |-> !$past(any_eff)); // R2
  AST_DRIVE_CAUSE: assert property (@(posedge clk) disable iff (por)
    $rose(pin_drive) |-> $past(req_eff[RQ_SUPMON])); // R4
  AST_FLAGS_SET: assert property (@(posedge clk) disable iff (por)
    sys_rst |-> (flags != '0)); // R6
endmodule

// File: rtl/rstctl_wdt_div.sv
module rstctl_wdt_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic por,
  input  logic sys_rst,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk or posedge por) begin
    if (por)                          div_cnt <= '0;
    else if (sys_rst)                 div_cnt <= '0;
    else if (div_cnt == DW'(DIV - 1)) div_cnt <= '0;
    else                              div_cnt <= div_cnt + 1'b1;
  end

  assign tick = ~sys_rst & (div_cnt == DW'(DIV - 1));

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (por)
    tick |=> !tick); // R9
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int HOLD    = 16,
  parameter int WDT_DIV = 12,
  parameter int ADDR_W  = 16,
  parameter int PORT_W  = 8
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              supmon_req,
  input  logic              pin_rst_n,
  input  logic              mcd_pulse,
  input  logic              wdt_req,
  input  logic              cmp_req,
  input  logic              sw_req,
  input  logic              flash_err_req,
  input  logic              rtc_req,
  output logic              sys_rst,
  output logic              pin_drive,
  output logic [NREQ:0]     rst_flags,
  output logic [ADDR_W-1:0] boot_addr,
  output logic [1:0]        clk_sel,
  output logic              wdt_en,
  output logic [3:0]        wdt_div,
  output logic              wdt_tick,
  output logic [PORT_W-1:0] port_val,
  output logic              port_od,
  output logic              port_pullup
);
  localparam int SYNC_STAGES = 2;

  logic [NREQ-1:0] req_raw, req_s;

  always_comb begin
    req_raw            = '0;
    req_raw[RQ_SUPMON] = supmon_req;
    req_raw[RQ_PIN]    = ~pin_rst_n;
    req_raw[RQ_MCD]    = mcd_pulse;
    req_raw[RQ_WDT]    = wdt_req;
    req_raw[RQ_CMP]    = cmp_req;
    req_raw[RQ_SW]     = sw_req;
    req_raw[RQ_FLASH]  = flash_err_req;
    req_raw[RQ_RTC]    = rtc_req;
  end

  rstctl_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .arst(por_req),
    .d   (req_raw),
    .q   (req_s)
  );

  rstctl_core #(.HOLD(HOLD), .MASK_D(SYNC_STAGES)) u_core (
    .clk      (clk),
    .por      (por_req),
    .req_s    (req_s),
    .sys_rst  (sys_rst),
    .pin_drive(pin_drive),
    .flags    (rst_flags)
  );

  rstctl_wdt_div #(.DIV(WDT_DIV)) u_wdiv (
    .clk    (clk),
    .por    (por_req),
    .sys_rst(sys_rst),
    .tick   (wdt_tick)
  );

  assign boot_addr   = '0;
  assign clk_sel     = CLK_INTOSC;
  assign wdt_en      = ~sys_rst;
  assign wdt_div     = 4'(WDT_DIV);
  assign port_val    = '1;
  assign port_od     = 1'b1;
  assign port_pullup = 1'b1;
endmodule

// File: tb/rstctl_top_test.sv
`timescale 1ns/1ps
module rstctl_top_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por = 1'b1, supmon = 1'b0, ext_low = 1'b0, mcd = 1'b0;
  logic wdt = 1'b0, cmp = 1'b0, sw = 1'b0, flash = 1'b0, rtc = 1'b0;
  logic pin_rst_n;
  logic sys_rst, pin_drive, wdt_en, wdt_tick, port_od, port_pullup;
  logic [8:0] rst_flags;
  logic [15:0] boot_addr;
  logic [1:0] clk_sel;
  logic [3:0] wdt_div;
  logic [7:0] port_val;

  assign pin_rst_n = ~(pin_drive | ext_low);

  rstctl_top uut (
    .clk(clk), .por_req(por), .supmon_req(supmon), .pin_rst_n(pin_rst_n),
    .mcd_pulse(mcd), .wdt_req(wdt), .cmp_req(cmp), .sw_req(sw),
    .flash_err_req(flash), .rtc_req(rtc), .sys_rst(sys_rst),
    .pin_drive(pin_drive), .rst_flags(rst_flags), .boot_addr(boot_addr),
    .clk_sel(clk_sel), .wdt_en(wdt_en), .wdt_div(wdt_div), .wdt_tick(wdt_tick),
    .port_val(port_val), .port_od(port_od), .port_pullup(port_pullup)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  logic [7:0] hist[$];
  bit m_rst = 1, m_cause = 1;
  int m_since = 0, m_div = 0;
  logic [8:0] m_flags = 9'h001;

  always @(posedge clk) begin
    logic [7:0] raw, eff;
    raw = {rtc, flash, sw, cmp, wdt, mcd, ext_low, supmon};
    if (por) begin
      hist = '{8'h00, 8'h00};
      m_rst = 1; m_cause = 1; m_since = 0; m_div = 0; m_flags = 9'h001;
    end else begin
      eff = hist[0];
      hist.push_back(raw);
      void'(hist.pop_front());
      if (m_rst) m_div = 0; else m_div = (m_div + 1) % 12;
      if (eff != 0) begin
        m_flags = m_rst ? (m_flags | {eff, 1'b0}) : {eff, 1'b0};
        if (eff[0]) m_cause = 1;
        m_rst = 1; m_since = 0;
      end else if (m_rst) begin
        m_since++;
        if (m_since == 16) begin m_rst = 0; m_cause = 0; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R1/R2/R3 sys_rst", 32'(sys_rst), 32'(m_rst));
    chk("R4 pin_drive", 32'(pin_drive), 32'(m_rst & m_cause));
    chk("R5/R6 rst_flags", 32'(rst_flags), 32'(m_flags));
    chk("R8 wdt_en", 32'(wdt_en), 32'(!m_rst));
    chk("R9 wdt_tick", 32'(wdt_tick), 32'(!m_rst && m_div == 11));
    chk("R8 defaults", {boot_addr, 10'd0, clk_sel, wdt_div}, {16'h0000, 10'd0, 2'd0, 4'd12});
    chk("R10 port", {22'd0, port_val, port_od, port_pullup}, {22'd0, 8'hFF, 1'b1, 1'b1});
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1;
    step(5); por = 0;                 // R3 power-on release
    step(40);
    supmon = 1; step(4); supmon = 0;  // R4 drive, R5 no self pin flag
    step(40);
    ext_low = 1; step(3); ext_low = 0; // R5 external pin, flag bit 2
    step(40);
    mcd = 1; step(1); mcd = 0;        // R7 one-cycle pulse stretched
    step(40);
    wdt = 1; step(2); wdt = 0; step(40);   // R1
    cmp = 1; step(2); cmp = 0; step(40);   // R1
    flash = 1; step(2); flash = 0; step(40); // R1
    rtc = 1; step(2); rtc = 0; step(40);   // R1
    wdt = 1; sw = 1; step(2); wdt = 0; sw = 0; step(40); // R6 simultaneous
    sw = 1; step(2); sw = 0; step(12);     // R6 OR-in during hold
    cmp = 1; step(1); cmp = 0; step(40);
    rtc = 1; step(30); rtc = 0; step(40);  // R2 long request
    supmon = 1; step(1); supmon = 0; step(10); // R4 drive with later source
    wdt = 1; step(1); wdt = 0; step(40);
    por = 1; step(3); por = 0; step(40);   // R3 second power-on
    step(30);                              // R9 several ticks
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end
endmodule